// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block keeps the transfer count and the upper address byte for each of the eight channels of a classic two-controller DMA engine. Software reaches the 16-bit counts through an 8-bit I/O data path. Each 16-bit access is split into a low byte and a high byte, and a per-controller byte pointer picks which one. A separate 8-bit page value per channel supplies bits 23:16 of the 24-bit memory address.

The channel arbiter sends one strobe per completed transfer, tagged with the channel number. The selected lane then counts down by one. Because the count wraps from 0000h to FFFFh on the last transfer, a lane programmed with N runs N+1 transfers. At that wrap the block raises a one-cycle terminal-count pulse for the lane.

What happens after terminal count depends on the lane's autoinitialize input:
- Autoinitialize enabled: the lane reloads its working count from the saved base count.
- Autoinitialize disabled: the lane holds FFFFh and ignores further strobes until software writes its count again.

Channels 0 to 3 count bytes. Channels 4 to 7 count 16-bit words.

Top module: `dma_cnt_unit`

## Requirements
- R1: Controller A (count ports 001h, 003h, 005h, 007h for channels 0..3) and controller B (count ports 0C2h, 0C6h, 0CAh, 0CEh for channels 4..7) each have a byte pointer. The first count access selects the low byte (bits 7:0) and the next one selects the high byte (bits 15:8). The pointer flips on every read or write of any count port in its own controller. Reset (rst_n low at a clock edge) or master clear (mclr high at a clock edge) returns both pointers to the low byte.
- R2: A write to a count port loads the addressed byte of both the base count and the working count. A read returns the addressed byte of the working count.
- R3: Each transfer strobe for a running channel lowers its working count by one, so a count of N produces terminal count on strobe N+1.
- R4: `tc` is combinational, one-hot, and active only in a strobe cycle. Bit k is high when the strobed channel k has a working count of 0000h.
- R5: At terminal count with autoinitialize enabled, the working count takes the base count. The base count is left as programmed, so every later cycle runs the same length.
- R6: At terminal count with autoinitialize disabled, the working count reads FFFFh.
- R7: After a terminal count without autoinitialize, the channel ignores further strobes: no decrement and no `tc`. A write to its count port makes it run again.
- R8: Page ports are 087h, 083h, 081h and 082h for channels 0..3, and 08Bh, 089h and 08Ah for channels 5..7. Channel 4 has none. Page ports are read and written as whole bytes, and accessing them does not move either byte pointer.
- R9: During a strobe, `xfer_page` shows the page of the strobed channel, or 00h for channel 4. `xfer_word` is 1 for channels 4..7 and 0 for channels 0..3.
- R10: A page value changes only through a write to its own page port. Transfers and autoinitialize reloads leave it alone.
- R11: If a host count write hits the same channel in the same cycle as its strobe, the write wins. The strobe is dropped and no `tc` is raised.
- R12: `io_rdata` is 00h when `io_rd` is low or the address matches no port. Writes to unmatched addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (pointers and run state only) |
| mclr | input | 1 | Master clear, synchronous, active high |
| io_addr | input | ADDR_W | Host I/O port address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational |
| autoinit | input | 8 | Autoinitialize enable, one bit per channel |
| xfer_stb | input | 1 | One completed transfer on `xfer_chan` |
| xfer_chan | input | 3 | Channel of the current transfer |
| tc | output | 8 | Terminal-count pulse, one-hot by channel |
| xfer_page | output | 8 | Address bits 23:16 for the strobed channel |
| xfer_word | output | 1 | Strobed channel counts 16-bit words |

## Verification
The byte pointer is the most fragile piece. The bench interleaves accesses to both controllers and to page ports, and puts a reset and a master clear between the two halves of a write. A shared pointer, or one moved by page accesses, would make the read-back bytes swap.

A lane counted for 260 strobes must raise `tc` on exactly the last one. An off-by-one compare would fire one strobe early or late.

After `tc` without autoinitialize, a lane that keeps counting would show FFFEh instead of FFFFh. A lane that reloads the page along with the count would lose its page byte.

The bench also drives a count write in the same cycle as a strobe on a lane holding zero. A design that honours the strobe would raise a false `tc`.

// File: rtl/dma_cnt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and port-decode functions for the DMA count unit.
// Assumes two controllers of four channels each, with fixed legacy port maps.
package dma_cnt_pkg;

    localparam int NCH  = 8;          // channels in total
    localparam int GRP  = 4;          // channels per controller
    localparam int NGRP = NCH / GRP;  // controllers
    localparam int CHW  = $clog2(NCH);
    localparam int DW   = 8;          // host data bus width
    localparam int CW   = 2 * DW;     // count width

    // Count port of a channel: odd ports low, stride 4 from 0C2h high.
    function automatic logic [7:0] cnt_port(input int ch);
        if (ch < GRP)
            return 8'(1 + 2 * ch);
        else
            return 8'(8'hC2 + 4 * (ch - GRP));
    endfunction

    // Page port of a channel (irregular map, channel 4 has none).
    function automatic logic [7:0] page_port(input int ch);
        case (ch)
            0: return 8'h87;
            1: return 8'h83;
            2: return 8'h81;
            3: return 8'h82;
            5: return 8'h8B;
            6: return 8'h89;
            7: return 8'h8A;
            default: return 8'h00;
        endcase
    endfunction

    // Whether a channel carries a page register.
    function automatic bit has_page(input int ch);
        return ch != GRP;
    endfunction

endpackage

// File: rtl/dma_cnt_ptr.sv
`timescale 1ns/1ps
// Module: byte pointer of one controller. Selects the low or the high byte
// of a 16-bit count port for the next host access.
// Assumes 'touch' is high for exactly one cycle per count-port access.
module dma_cnt_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic mclr,
    input  logic touch,
    output logic hi_o
);

    logic hi_q;

    // Pointer: cleared by reset or master clear, flipped on each access.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)
            hi_q <= 1'b0;
        else if (touch)
            hi_q <= ~hi_q;
    end

    assign hi_o = hi_q;

endmodule

// File: rtl/dma_cnt_chan.sv
`timescale 1ns/1ps
// Module: one channel lane. Holds the base and working counts and,
// when HAS_PAGE is set, the page byte.
// It counts down on strobes, flags terminal count at the 0 -> all-ones wrap,
// and reloads or stops after that wrap.
// Assumes wr_lo and wr_hi are never high together. The count registers and
// the page register are not reset, so their contents are undefined until
// software writes them.
module dma_cnt_chan #(
    parameter int DW       = 8,
    parameter int CW       = 16,
    parameter bit HAS_PAGE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mclr,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          wr_page,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    input  logic          autoinit,
    output logic [CW-1:0] cur_o,
    output logic [DW-1:0] page_o,
    output logic          done_o,
    output logic          tc_o
);

    logic [CW-1:0] base_q;
    logic [CW-1:0] cur_q;
    logic          done_q;
    logic          wr_any;
    logic          take;

    assign wr_any = wr_lo | wr_hi;
    assign take   = step & ~wr_any & ~done_q;
    assign tc_o   = take & (cur_q == '0);

    // Count registers: host byte writes first, otherwise decrement or reload.
    always_ff @(posedge clk) begin
        if (wr_any) begin
            if (wr_lo) begin
                base_q[DW-1:0] <= wdata;
                cur_q[DW-1:0]  <= wdata;
            end
            if (wr_hi) begin
                base_q[CW-1:DW] <= wdata;
                cur_q[CW-1:DW]  <= wdata;
            end
        end else if (take) begin
            if (tc_o && autoinit)
                cur_q <= base_q;
            else
                cur_q <= cur_q - 1'b1;
        end
    end

    // Stop flag: set by a terminal count without reload, cleared by a rewrite.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)
            done_q <= 1'b0;
        else if (wr_any)
            done_q <= 1'b0;
        else if (tc_o && !autoinit)
            done_q <= 1'b1;
    end

    generate
        if (HAS_PAGE) begin : g_page
            logic [DW-1:0] page_q;
            // Page byte: written only through its own port.
            always_ff @(posedge clk) begin
                if (wr_page)
                    page_q <= wdata;
            end
            assign page_o = page_q;
        end else begin : g_nopage
            logic unused_wr_page;
            assign unused_wr_page = wr_page;
            assign page_o = '0;
        end
    endgenerate

    assign cur_o  = cur_q;
    assign done_o = done_q;

endmodule

// File: rtl/dma_cnt_unit.sv
`timescale 1ns/1ps
// Module: address/count unit for eight DMA channels. Decodes the host I/O
// ports, runs one byte pointer per controller, and hands transfer strobes
// to the channel lanes.
// Assumes io_wr and io_rd are one-cycle strobes that are never high together,
// and that xfer_stb comes from an arbiter that already chose the channel.
module dma_cnt_unit
    import dma_cnt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic [NCH-1:0]    autoinit,
    input  logic              xfer_stb,
    input  logic [CHW-1:0]    xfer_chan,
    output logic [NCH-1:0]    tc,
    output logic [DW-1:0]     xfer_page,
    output logic              xfer_word
);

    logic [NCH-1:0]  cnt_hit;
    logic [NCH-1:0]  page_hit;
    logic [NCH-1:0]  cnt_wr_any;
    logic [NCH-1:0]  chan_done;
    logic [NGRP-1:0] ptr_hi;
    logic [CW-1:0]   cur_cnt [NCH];
    logic [DW-1:0]   page_q  [NCH];

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            logic touch;
            assign touch = (io_wr | io_rd) & (|cnt_hit[g*GRP +: GRP]);
            dma_cnt_ptr u_ptr (
                .clk   (clk),
                .rst_n (rst_n),
                .mclr  (mclr),
                .touch (touch),
                .hi_o  (ptr_hi[g])
            );
        end

        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic wr_lo;
            logic wr_hi;
            logic step;
            assign cnt_hit[c]    = (io_addr == ADDR_W'(cnt_port(c)));
            assign page_hit[c]   = has_page(c) && (io_addr == ADDR_W'(page_port(c)));
            assign wr_lo         = io_wr & cnt_hit[c] & ~ptr_hi[c / GRP];
            assign wr_hi         = io_wr & cnt_hit[c] &  ptr_hi[c / GRP];
            assign cnt_wr_any[c] = wr_lo | wr_hi;
            assign step          = xfer_stb && (xfer_chan == CHW'(c));
            dma_cnt_chan #(
                .DW       (DW),
                .CW       (CW),
                .HAS_PAGE (has_page(c))
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .mclr     (mclr),
                .wr_lo    (wr_lo),
                .wr_hi    (wr_hi),
                .wr_page  (io_wr & page_hit[c]),
                .wdata    (io_wdata),
                .step     (step),
                .autoinit (autoinit[c]),
                .cur_o    (cur_cnt[c]),
                .page_o   (page_q[c]),
                .done_o   (chan_done[c]),
                .tc_o     (tc[c])
            );
        end
    endgenerate

    // Read mux: merge the selected count byte or page byte during a read.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            for (int c = 0; c < NCH; c++) begin
                if (cnt_hit[c])
                    io_rdata = io_rdata | (ptr_hi[c / GRP] ? cur_cnt[c][CW-1:DW]
                                                           : cur_cnt[c][DW-1:0]);
                if (page_hit[c])
                    io_rdata = io_rdata | page_q[c];
            end
        end
    end

    // Transfer-side outputs: page of the strobed lane and its counting unit.
    assign xfer_page = page_q[xfer_chan];
    assign xfer_word = xfer_chan[CHW-1];

endmodule

// File: rtl/dma_cnt_unit_chk.sv
`timescale 1ns/1ps
// Module: property checker for dma_cnt_unit, attached by bind.
// Assumes the host strobes follow the rules stated on the top module.
module dma_cnt_unit_chk
    import dma_cnt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mclr,
    input logic              io_wr,
    input logic [NCH-1:0]    autoinit,
    input logic              xfer_stb,
    input logic [CHW-1:0]    xfer_chan,
    input logic [NCH-1:0]    tc,
    input logic [NCH-1:0]    cnt_wr_any,
    input logic [NCH-1:0]    chan_done,
    input logic [NGRP-1:0]   ptr_hi,
    input logic [CW-1:0]     cur_cnt [NCH],
    input logic [DW-1:0]     page_q  [NCH]
);

    a_r4_tc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc));

    a_r4_tc_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc) |-> (xfer_stb && tc[xfer_chan]));

    a_r1_mclr_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (ptr_hi == '0));

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !io_wr && !chan_done[xfer_chan] && cur_cnt[xfer_chan] != '0)
        |=> (cur_cnt[$past(xfer_chan)] == $past(cur_cnt[xfer_chan]) - 1'b1));

    a_r6_hold_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && tc[xfer_chan] && !autoinit[xfer_chan])
        |=> (cur_cnt[$past(xfer_chan)] == '1));

    a_r7_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && chan_done[xfer_chan]) |-> (tc == '0));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && cnt_wr_any[xfer_chan]) |-> (tc == '0));

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_pg
            a_r10_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !io_wr |=> (page_q[k] == $past(page_q[k])));
        end
    endgenerate

endmodule

bind dma_cnt_unit dma_cnt_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclr       (mclr),
    .io_wr      (io_wr),
    .autoinit   (autoinit),
    .xfer_stb   (xfer_stb),
    .xfer_chan  (xfer_chan),
    .tc         (tc),
    .cnt_wr_any (cnt_wr_any),
    .chan_done  (chan_done),
    .ptr_hi     (ptr_hi),
    .cur_cnt    (cur_cnt),
    .page_q     (page_q)
);

// File: tb/test_dma_cnt_unit.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed tests for reset, long counts,
// stop and reload, page behaviour and write/strobe collisions.
module test_dma_cnt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclr = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [7:0]  autoinit = 8'b0000_0100;
    logic        xfer_stb = 1'b0;
    logic [2:0]  xfer_chan = '0;
    logic [7:0]  tc;
    logic [7:0]  xfer_page;
    logic        xfer_word;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dma_cnt_unit i_dma_cnt_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .mclr      (mclr),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .autoinit  (autoinit),
        .xfer_stb  (xfer_stb),
        .xfer_chan (xfer_chan),
        .tc        (tc),
        .xfer_page (xfer_page),
        .xfer_word (xfer_word)
    );

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_XF = 2'd2;
    localparam int NV = 36;
    // {req, op, addr, data/channel, expected}
    localparam logic [29:0] VEC [NV] = '{
        {4'd1,  OP_WR, 8'h03, 8'h02, 8'h00},  // R1 ch1 low byte
        {4'd1,  OP_WR, 8'h03, 8'h00, 8'h00},  // R1 ch1 high byte
        {4'd2,  OP_RD, 8'h03, 8'h00, 8'h02},  // R2
        {4'd2,  OP_RD, 8'h03, 8'h00, 8'h00},  // R2
        {4'd3,  OP_XF, 8'h00, 8'h01, 8'h00},  // R3 2 -> 1
        {4'd3,  OP_XF, 8'h00, 8'h01, 8'h00},  // R3 1 -> 0
        {4'd4,  OP_XF, 8'h00, 8'h01, 8'h02},  // R4 wrap, tc on ch1
        {4'd6,  OP_RD, 8'h03, 8'h00, 8'hFF},  // R6
        {4'd6,  OP_RD, 8'h03, 8'h00, 8'hFF},  // R6
        {4'd7,  OP_XF, 8'h00, 8'h01, 8'h00},  // R7 stopped lane
        {4'd7,  OP_RD, 8'h03, 8'h00, 8'hFF},  // R7
        {4'd7,  OP_RD, 8'h03, 8'h00, 8'hFF},  // R7
        {4'd2,  OP_WR, 8'h05, 8'h01, 8'h00},  // R2 ch2 = 0001h
        {4'd2,  OP_WR, 8'h05, 8'h00, 8'h00},
        {4'd3,  OP_XF, 8'h00, 8'h02, 8'h00},  // R3 1 -> 0
        {4'd5,  OP_XF, 8'h00, 8'h02, 8'h04},  // R5 tc and reload
        {4'd5,  OP_RD, 8'h05, 8'h00, 8'h01},  // R5
        {4'd5,  OP_RD, 8'h05, 8'h00, 8'h00},  // R5
        {4'd1,  OP_WR, 8'hCA, 8'h00, 8'h00},  // R1 ch6 via controller B
        {4'd1,  OP_WR, 8'hCA, 8'h01, 8'h00},
        {4'd3,  OP_XF, 8'h00, 8'h06, 8'h00},  // R3 0100h -> 00FFh
        {4'd3,  OP_RD, 8'hCA, 8'h00, 8'hFF},  // R3
        {4'd3,  OP_RD, 8'hCA, 8'h00, 8'h00},  // R3
        {4'd8,  OP_WR, 8'h89, 8'h5A, 8'h00},  // R8 ch6 page
        {4'd8,  OP_RD, 8'h89, 8'h00, 8'h5A},  // R8
        {4'd8,  OP_WR, 8'h87, 8'h12, 8'h00},  // R8 ch0 page
        {4'd8,  OP_RD, 8'h87, 8'h00, 8'h12},  // R8
        {4'd12, OP_RD, 8'hF0, 8'h00, 8'h00},  // R12 unmatched read
        {4'd8,  OP_RD, 8'hCA, 8'h00, 8'hFF},  // R8 pointer untouched by page
        {4'd8,  OP_RD, 8'hCA, 8'h00, 8'h00},  // R8
        {4'd1,  OP_WR, 8'h01, 8'h03, 8'h00},  // R1 ch0 low
        {4'd1,  OP_WR, 8'hC2, 8'h07, 8'h00},  // R1 ch4 low (other pointer)
        {4'd1,  OP_WR, 8'h01, 8'h00, 8'h00},  // R1 ch0 high
        {4'd1,  OP_WR, 8'hC2, 8'h00, 8'h00},  // R1 ch4 high
        {4'd1,  OP_RD, 8'h01, 8'h00, 8'h03},  // R1
        {4'd1,  OP_RD, 8'h01, 8'h00, 8'h00}   // R1
    };

    // One check: count it, report a failure with actual and expected values.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = 16'(a); io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = 16'(a); io_rd = 1'b1;
        #5;
        check(io_rdata == exp, req, io_rdata, exp);
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic xfer(input logic [2:0] ch, input logic [7:0] exp_tc, input string req,
                        input bit chk_pg, input logic [7:0] exp_pg, input logic exp_word);
        @(negedge clk);
        xfer_chan = ch; xfer_stb = 1'b1;
        #5;
        check(tc == exp_tc, req, tc, exp_tc);
        if (chk_pg) begin
            check(xfer_page == exp_pg, "R9 page", xfer_page, exp_pg);
            check(xfer_word == exp_word, "R9 word", xfer_word, exp_word);
        end
        @(posedge clk); #1;
        xfer_stb = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string tag;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state: no tc while idle, unmatched reads are zero (R4, R12).
        @(negedge clk);
        check(tc == 8'h00, "R4 reset", tc, 0);
        io_addr = 16'h0F0; io_rd = 1'b1; #5;
        check(io_rdata == 8'h00, "R12 reset", io_rdata, 0);
        @(posedge clk); #1 io_rd = 1'b0;

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d vec%0d", VEC[i][29:26], i);
            case (VEC[i][25:24])
                OP_WR: io_write(VEC[i][23:16], VEC[i][15:8]);
                OP_RD: io_read(VEC[i][23:16], VEC[i][7:0], tag);
                default: xfer(VEC[i][10:8], VEC[i][7:0], tag, 1'b0, 8'h00, 1'b0);
            endcase
        end

        // R1: master clear between halves of a write returns to the low byte.
        io_write(8'h07, 8'hAA);
        @(negedge clk); mclr = 1'b1; @(posedge clk); #1 mclr = 1'b0;
        io_write(8'h07, 8'h11);
        io_write(8'h07, 8'h22);
        io_read(8'h07, 8'h11, "R1 mclr lo");
        io_read(8'h07, 8'h22, "R1 mclr hi");
        // R1: reset does the same on controller B.
        io_write(8'hC6, 8'h44);
        @(negedge clk); rst_n = 1'b0; @(posedge clk); #1 rst_n = 1'b1;
        io_write(8'hC6, 8'h55);
        io_write(8'hC6, 8'h66);
        io_read(8'hC6, 8'h55, "R1 reset lo");
        io_read(8'hC6, 8'h66, "R1 reset hi");

        // R3: count 0103h gives tc on strobe 260.
        io_write(8'hCE, 8'h03);
        io_write(8'hCE, 8'h01);
        n = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); xfer_chan = 3'd7; xfer_stb = 1'b1; #5;
            n++;
            if (tc[7]) begin
                @(posedge clk); #1 xfer_stb = 1'b0;
                break;
            end
            @(posedge clk); #1 xfer_stb = 1'b0;
        end
        check(n == 260, "R3 length", n, 260);
        io_read(8'hCE, 8'hFF, "R6 lo");
        io_read(8'hCE, 8'hFF, "R6 hi");

        // R5: autoinit lane keeps producing equal-length cycles.
        xfer(3'd2, 8'h00, "R5 again", 1'b0, 8'h00, 1'b0);
        xfer(3'd2, 8'h04, "R5 tc again", 1'b0, 8'h00, 1'b0);

        // R7: rewriting a stopped lane makes it run again.
        io_write(8'h03, 8'h00);
        io_write(8'h03, 8'h00);
        xfer(3'd1, 8'h02, "R7 rerun", 1'b0, 8'h00, 1'b0);

        // R11: count write and strobe to the same zero lane in one cycle.
        io_write(8'h07, 8'h00);
        io_write(8'h07, 8'h00);
        @(negedge clk);
        io_addr = 16'h007; io_wdata = 8'h05; io_wr = 1'b1;
        xfer_chan = 3'd3; xfer_stb = 1'b1;
        #5;
        check(tc == 8'h00, "R11 tc", tc, 0);
        @(posedge clk); #1 io_wr = 1'b0; xfer_stb = 1'b0;
        io_write(8'h07, 8'h00);
        io_read(8'h07, 8'h05, "R11 lo");
        io_read(8'h07, 8'h00, "R11 hi");
        xfer(3'd3, 8'h00, "R11 after", 1'b0, 8'h00, 1'b0);
        io_read(8'h07, 8'h04, "R11 dec");
        io_read(8'h07, 8'h00, "R11 dec hi");

        // R9: page and word flag for the strobed lane.
        xfer(3'd6, 8'h00, "R9 ch6", 1'b1, 8'h5A, 1'b1);
        xfer(3'd0, 8'h00, "R9 ch0", 1'b1, 8'h12, 1'b0);
        xfer(3'd4, 8'h00, "R9 ch4", 1'b1, 8'h00, 1'b1);

        // R10: page survives an autoinit reload.
        autoinit[5] = 1'b1;
        io_write(8'h8B, 8'h33);
        io_write(8'hC6, 8'h00);
        io_write(8'hC6, 8'h00);
        xfer(3'd5, 8'h20, "R10 tc", 1'b1, 8'h33, 1'b1);
        io_read(8'h8B, 8'h33, "R10 page");
        io_read(8'hC6, 8'h00, "R5 reload lo");
        io_read(8'hC6, 8'h00, "R5 reload hi");

        // R12: unmatched write leaves pages and counts alone.
        io_write(8'h80, 8'hEE);
        io_read(8'h89, 8'h5A, "R12 page");
        io_read(8'h05, 8'h01, "R12 count");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule